// File: doc/BRIEF.md
# Interrupt Entry and Return Unit

This block holds the architectural program counter, the machine state word and the registers that an interrupt handler uses. It decides each cycle whether to take an alignment exception, an external interrupt or a return-from-interrupt, and applies the matching register updates. The surrounding core reports the address of the instruction in the memory stage and the address of the instruction after it. It also reports the type, effective address and storage attribute of any data access, a request to retire normally, and any move into the machine state word.

An alignment exception is raised whenever a data access breaks the alignment rule for its access class. It cannot be masked. In the same cycle the block raises a kill output so that the faulting instruction does not complete. An external request is captured and held pending until the external-enable bit of the machine state word lets it in. On either entry, the block saves the return address and the full state word, and it clears the handler-unsafe status bits. The new program counter is a 16-bit prefix followed by a fixed low half for each class. A return copies both saved values back.

Top module: `irq_state_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `pc_o`, `msr_o`, `srr0_o`, `srr1_o` and `dear_o` all zero. Any held external request is dropped.
- R2: `kill_o` is high in the same cycle as these accesses, and only these. Codes are on `mem_op`. Code 1 (block zero) faults when `mem_uncached` is 1. Codes 2, 3 and 4 (cache read, load-reserved, store-conditional) fault when `mem_ea[1:0]` is nonzero. Code 5 (auxiliary halfword) faults when `mem_ea[0]` is 1. Codes 6 and 7 (auxiliary word and doubleword) fault when `mem_ea[1:0]` is nonzero. Code 8 (auxiliary quadword) faults when `mem_ea[3:0]` is nonzero. Codes 0, 9 and 10 to 15 never fault.
- R3: An alignment fault is taken whatever the value of `msr_o`, including all zeros.
- R4: On an alignment fault, after the edge `srr0_o` equals `instr_pc` and `dear_o` equals `mem_ea`. `pc_o` equals `{vec_prefix, 16'h0600}`. `step` has no effect in that cycle.
- R5: An external request is taken only while `msr_o[0]` (external enable) is 1. On taking it, `srr0_o` becomes `instr_next` and `pc_o` becomes `{vec_prefix, 16'h0500}`.
- R6: On either entry, `srr1_o` becomes the whole `msr_o` value from before the edge.
- R7: On either entry, `msr_o` bits 0 and 4 to 13 become 0. Bits 1, 2, 3 and 14 to 31 keep their values.
- R8: When `ret_req` is high and there is no alignment fault, `pc_o` takes the value of `srr0_o` and `msr_o` takes the value of `srr1_o`.
- R9: Priority is alignment fault first, then return, then external interrupt. An external interrupt is also not taken in a cycle with `msr_wr_en` high. In a cycle where an event is taken, `step` and `msr_wr_en` have no effect.
- R10: A pulse on `irq_req` that cannot be taken stays pending. It is taken in the first later cycle that allows it.
- R11: In a cycle with no event, `step` loads `pc_o` with `instr_next` and `msr_wr_en` loads `msr_o` with `msr_wr_val`. `srr0_o`, `srr1_o` and `dear_o` are left unchanged.
- R12: All register updates for one cycle appear together after its clock edge. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_pc | input | 32 | Address of the instruction in the memory stage |
| instr_next | input | 32 | Address of the next sequential instruction |
| step | input | 1 | Instruction retires normally; advance the program counter |
| msr_wr_en | input | 1 | Move into the machine state word this cycle |
| msr_wr_val | input | 32 | Value for a move into the machine state word |
| vec_prefix | input | 16 | Upper half of every vector address |
| mem_op | input | 4 | Data access class code (see R2) |
| mem_ea | input | 32 | Effective address of the data access |
| mem_uncached | input | 1 | Target is non-cacheable or write-through |
| irq_req | input | 1 | External interrupt request |
| ret_req | input | 1 | Return-from-interrupt strobe |
| pc_o | output | 32 | Program counter |
| msr_o | output | 32 | Machine state word |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state word |
| dear_o | output | 32 | Address of the last misaligned access |
| kill_o | output | 1 | Suppress completion of the current instruction |

## Verification
The bench targets collisions: a fault, a return and a request in one cycle. It also covers a request that arrives while external enable is clear, and a request that arrives in the same cycle as a move that sets external enable. A wrong priority would vector to 0x0500 or restore the saved word instead of going to 0x0600. A lost pending flag would never reach the external handler. A wrong clear mask would leave user mode or translation on inside the handler. The address boundaries of each access class (offsets 1, 2 and 8 within a quadword) show up off-by-one masks as faults that are missed or invented. A fault with the state word all zero shows whether the fault was wrongly gated by a status bit.

// File: rtl/ise_pkg.sv
`timescale 1ns/1ps
package ise_pkg;
  localparam int XLEN      = 32;
  localparam int VEC_LO_W  = 16;
  localparam int VEC_HI_W  = XLEN - VEC_LO_W;
  localparam int OP_W      = 4;
  localparam int EA_LO_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE      = 4'd0,
    OP_BLK_ZERO  = 4'd1,
    OP_CACHE_RD  = 4'd2,
    OP_LD_RESV   = 4'd3,
    OP_ST_COND   = 4'd4,
    OP_AUX_HALF  = 4'd5,
    OP_AUX_WORD  = 4'd6,
    OP_AUX_DWORD = 4'd7,
    OP_AUX_QUAD  = 4'd8,
    OP_PLAIN     = 4'd9
  } mem_op_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ALIGN  = 2'd1,
    EV_RETURN = 2'd2,
    EV_EXTERN = 2'd3
  } event_e;

  // state word layout: bit 0 external enable, bits 1..3 kept, 4..13 cleared
  localparam int MSR_EXT_EN = 0;
  localparam int KEEP_LO    = 1;
  localparam int KEEP_HI    = 3;
  localparam int CLR_LO     = 4;
  localparam int CLR_HI     = 13;

  localparam logic [VEC_LO_W-1:0] VEC_EXT_LO   = 16'h0500;
  localparam logic [VEC_LO_W-1:0] VEC_ALIGN_LO = 16'h0600;

  function automatic logic [XLEN-1:0] entry_clear_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[MSR_EXT_EN] = 1'b1;
    for (int i = CLR_LO; i <= CLR_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] entry_msr(input logic [XLEN-1:0] cur);
    return cur & ~entry_clear_mask();
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(input logic [VEC_HI_W-1:0] hi,
                                                  input logic [VEC_LO_W-1:0] lo);
    return {hi, lo};
  endfunction

  // true when any of the lowest nbits address bits is set
  function automatic logic low_bits_set(input logic [EA_LO_W-1:0] ea, input int nbits);
    logic [EA_LO_W-1:0] m;
    m = EA_LO_W'((1 << nbits) - 1);
    return |(ea & m);
  endfunction
endpackage

// File: rtl/ise_align_chk.sv
`timescale 1ns/1ps
module ise_align_chk
  import ise_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    op,
  input  logic [EA_LO_W-1:0] ea_lo,
  input  logic               uncached,
  output logic               fault
);
  localparam int N_AUX = 4;
  localparam int AUX_LSBS [N_AUX] = '{1, 2, 2, 4};

  logic [N_AUX-1:0] aux_hit;
  logic             resv_hit;
  logic             zero_hit;

  // one detector per auxiliary access size
  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    localparam int NB = AUX_LSBS[g];
    localparam logic [OP_W-1:0] CODE = OP_W'(int'(OP_AUX_HALF) + g);
    assign aux_hit[g] = (op == CODE) && low_bits_set(ea_lo, NB);
  end

  always_comb begin
    resv_hit = 1'b0;
    if (op == OP_CACHE_RD || op == OP_LD_RESV || op == OP_ST_COND)
      resv_hit = low_bits_set(ea_lo, 2);
  end

  assign zero_hit = (op == OP_BLK_ZERO) && uncached;
  assign fault    = zero_hit | resv_hit | (|aux_hit);

  AST_PLAIN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE || op == OP_PLAIN || op > OP_PLAIN) |-> !fault); // R2
  AST_ALIGNED_QUAD_OK: assert property (@(posedge clk) disable iff (rst)
    (ea_lo == '0 && op != OP_BLK_ZERO) |-> !fault); // R2
endmodule

// File: rtl/ise_event_arb.sv
`timescale 1ns/1ps
module ise_event_arb
  import ise_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   fault,
  input  logic   ret_req,
  input  logic   irq_req,
  input  logic   msr_wr_en,
  input  logic   ext_en,
  output event_e ev
);
  logic pend_q;
  logic want_ext;
  logic take_ext;

  assign want_ext = irq_req | pend_q;
  assign take_ext = want_ext & ext_en & ~fault & ~ret_req & ~msr_wr_en;

  always_comb begin
    if (fault)         ev = EV_ALIGN;
    else if (ret_req)  ev = EV_RETURN;
    else if (take_ext) ev = EV_EXTERN;
    else               ev = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= want_ext & ~take_ext;
  end

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_EXTERN) |-> ext_en); // R5
  AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (rst)
    fault |-> (ev == EV_ALIGN)); // R3
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    (want_ext && ev != EV_EXTERN) |=> pend_q); // R10
  AST_RET_OVER_EXT: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !fault) |-> (ev == EV_RETURN)); // R9
endmodule

// File: rtl/ise_arch_regs.sv
`timescale 1ns/1ps
module ise_arch_regs
  import ise_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  event_e              ev,
  input  logic [XLEN-1:0]     instr_pc,
  input  logic [XLEN-1:0]     instr_next,
  input  logic                step,
  input  logic                msr_wr_en,
  input  logic [XLEN-1:0]     msr_wr_val,
  input  logic [VEC_HI_W-1:0] vec_hi,
  input  logic [XLEN-1:0]     ea,
  output logic [XLEN-1:0]     pc_q,
  output logic [XLEN-1:0]     msr_q,
  output logic [XLEN-1:0]     srr0_q,
  output logic [XLEN-1:0]     srr1_q,
  output logic [XLEN-1:0]     dear_q
);
  logic ev_entry;
  assign ev_entry = (ev == EV_ALIGN) || (ev == EV_EXTERN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      msr_q  <= '0;
      srr0_q <= '0;
      srr1_q <= '0;
      dear_q <= '0;
    end else begin
      unique case (ev)
        EV_ALIGN: begin
          srr0_q <= instr_pc;
          srr1_q <= msr_q;
          msr_q  <= entry_msr(msr_q);
          dear_q <= ea;
          pc_q   <= vector_addr(vec_hi, VEC_ALIGN_LO);
        end
        EV_EXTERN: begin
          srr0_q <= instr_next;
          srr1_q <= msr_q;
          msr_q  <= entry_msr(msr_q);
          pc_q   <= vector_addr(vec_hi, VEC_EXT_LO);
        end
        EV_RETURN: begin
          pc_q  <= srr0_q;
          msr_q <= srr1_q;
        end
        default: begin
          if (step)      pc_q  <= instr_next;
          if (msr_wr_en) msr_q <= msr_wr_val;
        end
      endcase
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && msr_q == '0 && dear_q == '0)); // R1
  AST_ALIGN_SAVE: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_ALIGN) |=> (srr0_q == $past(instr_pc) && dear_q == $past(ea)
                          && pc_q[VEC_LO_W-1:0] == VEC_ALIGN_LO)); // R4
  AST_EXT_SAVE: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_EXTERN) |=> (srr0_q == $past(instr_next)
                           && pc_q[VEC_LO_W-1:0] == VEC_EXT_LO)); // R5
  AST_SAVE_WORD: assert property (@(posedge clk) disable iff (rst)
    ev_entry |=> (srr1_q == $past(msr_q))); // R6
  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ev_entry |=> ((msr_q & entry_clear_mask()) == '0
                  && msr_q[KEEP_HI:KEEP_LO] == $past(msr_q[KEEP_HI:KEEP_LO]))); // R7
  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_RETURN) |=> (pc_q == $past(srr0_q) && msr_q == $past(srr1_q))); // R8
  AST_QUIET_SAVES: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NONE) |=> ($stable(srr0_q) && $stable(srr1_q) && $stable(dear_q))); // R11
endmodule

// File: rtl/irq_state_engine.sv
`timescale 1ns/1ps
module irq_state_engine
  import ise_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [XLEN-1:0]     instr_pc,
  input  logic [XLEN-1:0]     instr_next,
  input  logic                step,
  input  logic                msr_wr_en,
  input  logic [XLEN-1:0]     msr_wr_val,
  input  logic [VEC_HI_W-1:0] vec_prefix,
  input  logic [OP_W-1:0]     mem_op,
  input  logic [XLEN-1:0]     mem_ea,
  input  logic                mem_uncached,
  input  logic                irq_req,
  input  logic                ret_req,
  output logic [XLEN-1:0]     pc_o,
  output logic [XLEN-1:0]     msr_o,
  output logic [XLEN-1:0]     srr0_o,
  output logic [XLEN-1:0]     srr1_o,
  output logic [XLEN-1:0]     dear_o,
  output logic                kill_o
);
  logic   align_fault;
  event_e ev;

  ise_align_chk u_align (
    .clk      (clk),
    .rst      (rst),
    .op       (mem_op),
    .ea_lo    (mem_ea[EA_LO_W-1:0]),
    .uncached (mem_uncached),
    .fault    (align_fault)
  );

  ise_event_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .fault     (align_fault),
    .ret_req   (ret_req),
    .irq_req   (irq_req),
    .msr_wr_en (msr_wr_en),
    .ext_en    (msr_o[MSR_EXT_EN]),
    .ev        (ev)
  );

  ise_arch_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .instr_pc   (instr_pc),
    .instr_next (instr_next),
    .step       (step),
    .msr_wr_en  (msr_wr_en),
    .msr_wr_val (msr_wr_val),
    .vec_hi     (vec_prefix),
    .ea         (mem_ea),
    .pc_q       (pc_o),
    .msr_q      (msr_o),
    .srr0_q     (srr0_o),
    .srr1_q     (srr1_o),
    .dear_q     (dear_o)
  );

  assign kill_o = align_fault;

  AST_KILL_VECTORS: assert property (@(posedge clk) disable iff (rst)
    kill_o |=> (pc_o == {$past(vec_prefix), VEC_ALIGN_LO})); // R4
  AST_KILL_BLOCKS_STEP: assert property (@(posedge clk) disable iff (rst)
    (kill_o && step) |=> (pc_o != $past(instr_next) || $past(instr_next) == {$past(vec_prefix), VEC_ALIGN_LO})); // R9
endmodule

// File: tb/irq_state_engine_bench.sv
`timescale 1ns/1ps
module irq_state_engine_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr_pc, instr_next, msr_wr_val, mem_ea;
  logic [15:0] vec_prefix;
  logic [3:0]  mem_op;
  logic        step, msr_wr_en, mem_uncached, irq_req, ret_req;
  logic [31:0] pc_o, msr_o, srr0_o, srr1_o, dear_o;
  logic        kill_o;

  int total = 0;
  int fails = 0;

  logic [31:0] m_pc, m_msr, m_srr0, m_srr1, m_dear;
  bit          m_pend;

  irq_state_engine u_irq_state_engine (
    .clk(clk), .rst(rst), .instr_pc(instr_pc), .instr_next(instr_next),
    .step(step), .msr_wr_en(msr_wr_en), .msr_wr_val(msr_wr_val),
    .vec_prefix(vec_prefix), .mem_op(mem_op), .mem_ea(mem_ea),
    .mem_uncached(mem_uncached), .irq_req(irq_req), .ret_req(ret_req),
    .pc_o(pc_o), .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .dear_o(dear_o), .kill_o(kill_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [3:0] op, input logic [31:0] ea, input bit nc);
    case (op)
      4'd1:             return nc;
      4'd2, 4'd3, 4'd4: return (ea % 4) != 0;
      4'd5:             return (ea % 2) != 0;
      4'd6, 4'd7:       return (ea % 4) != 0;
      4'd8:             return (ea % 16) != 0;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_entry(input logic [31:0] m);
    logic [31:0] r;
    r = m;
    r[0] = 1'b0;
    for (int i = 4; i < 14; i++) r[i] = 1'b0;
    return r;
  endfunction

  task automatic idle_inputs();
    step = 0; msr_wr_en = 0; msr_wr_val = '0; mem_op = 4'd0; mem_ea = '0;
    mem_uncached = 0; irq_req = 0; ret_req = 0;
  endtask

  // evaluates the current inputs, crosses one edge, compares all outputs
  task automatic run_cycle();
    bit f, want, take;
    string tag, mtag, stag;
    #1;
    f = exp_fault(mem_op, mem_ea, mem_uncached);
    chk("R2 kill", {31'd0, kill_o}, {31'd0, f});
    chk("R12 pc before edge", pc_o, m_pc);
    chk("R12 msr before edge", msr_o, m_msr);
    want = irq_req | m_pend;
    take = want & m_msr[0] & !f & !ret_req & !msr_wr_en;
    if (f) begin
      m_srr0 = instr_pc; m_srr1 = m_msr; m_msr = exp_entry(m_msr);
      m_dear = mem_ea; m_pc = {vec_prefix, 16'h0600}; tag = "R4";
    end else if (ret_req) begin
      m_pc = m_srr0; m_msr = m_srr1; tag = "R8";
    end else if (take) begin
      m_srr0 = instr_next; m_srr1 = m_msr; m_msr = exp_entry(m_msr);
      m_pc = {vec_prefix, 16'h0500}; tag = "R5";
    end else begin
      if (step) m_pc = instr_next;
      if (msr_wr_en) m_msr = msr_wr_val;
      tag = "R11";
    end
    m_pend = want & !take;
    mtag = (tag == "R4" || tag == "R5") ? "R7" : tag;
    stag = (tag == "R4" || tag == "R5") ? "R6" : tag;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pc"}, pc_o, m_pc);
    chk({mtag, " msr"}, msr_o, m_msr);
    chk({tag, " srr0"}, srr0_o, m_srr0);
    chk({stag, " srr1"}, srr1_o, m_srr1);
    chk({tag, " dear"}, dear_o, m_dear);
  endtask

  initial begin
    #1_600_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    rst = 1; idle_inputs();
    instr_pc = 32'h0000_1000; instr_next = 32'h0000_1004; vec_prefix = 16'hC0DE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 msr", msr_o, 32'd0);
    chk("R1 srr0", srr0_o, 32'd0);
    chk("R1 srr1", srr1_o, 32'd0);
    chk("R1 dear", dear_o, 32'd0);
    m_pc = 0; m_msr = 0; m_srr0 = 0; m_srr1 = 0; m_dear = 0; m_pend = 0;

    // R3: fault taken with state word all zero, step ignored
    mem_op = 4'd6; mem_ea = 32'h0000_2002; step = 1;
    run_cycle();
    chk("R3 vector with zero state", pc_o, 32'hC0DE_0600);
    chk("R3 dear", dear_o, 32'h0000_2002);

    // all ones into the state word, then fault: R7 mask check
    idle_inputs(); msr_wr_en = 1; msr_wr_val = 32'hFFFF_FFFF;
    run_cycle();
    idle_inputs(); mem_op = 4'd8; mem_ea = 32'h0000_3008; instr_pc = 32'h0000_2000;
    run_cycle();
    chk("R7 entry mask", msr_o, 32'hFFFF_C00E);

    // R9: fault, return and request together
    idle_inputs(); msr_wr_en = 1; msr_wr_val = 32'h0000_0001;
    run_cycle();
    idle_inputs(); mem_op = 4'd2; mem_ea = 32'h0000_4001; ret_req = 1; irq_req = 1;
    instr_pc = 32'h0000_5000;
    run_cycle();
    chk("R9 fault over return and irq", pc_o, 32'hC0DE_0600);

    // R10: request held while enable clear
    idle_inputs();
    repeat (3) run_cycle();
    chk("R10 still waiting", pc_o, 32'hC0DE_0600);
    msr_wr_en = 1; msr_wr_val = 32'h0000_0001; irq_req = 0;
    run_cycle();
    chk("R9 no take on write cycle", pc_o, 32'hC0DE_0600);
    idle_inputs(); instr_next = 32'h0000_6004;
    run_cycle();
    chk("R10 pending taken", pc_o, 32'hC0DE_0500);
    chk("R5 save next", srr0_o, 32'h0000_6004);

    // R8: return
    idle_inputs(); ret_req = 1;
    run_cycle();
    chk("R8 restore pc", pc_o, 32'h0000_6004);
    chk("R8 restore msr", msr_o, 32'h0000_0001);

    // boundary offsets per class
    for (int op = 1; op <= 9; op++) begin
      for (int off = 0; off < 16; off += 1) begin
        idle_inputs(); mem_op = 4'(op); mem_ea = 32'h0000_8000 + 32'(off);
        mem_uncached = off[0];
        run_cycle();
      end
    end

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      instr_pc     = $urandom() & 32'hFFFF_FFFC;
      instr_next   = instr_pc + 32'd4;
      step         = ($urandom_range(0, 3) != 0);
      msr_wr_en    = ($urandom_range(0, 5) == 0);
      msr_wr_val   = $urandom() | {31'd0, ($urandom_range(0, 3) != 0)};
      vec_prefix   = 16'($urandom());
      mem_op       = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      mem_ea       = $urandom();
      mem_uncached = $urandom_range(0, 1) == 1;
      irq_req      = ($urandom_range(0, 5) == 0);
      ret_req      = ($urandom_range(0, 9) == 0);
      run_cycle();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule